// File: doc/BRIEF.md
# Reconfigurable Arithmetic Pipeline

This block is a streaming integer datapath built from three functional stages: a multiplier, an adder and a bitwise OR unit. Each stage registers its result. Each of the two operands of a stage comes through its own four-way selector. The selector picks either an external operand that arrives with the stream element, or the registered result of one of the stages. A configuration word sets all six operand selectors and a final-result selector. This lets one piece of hardware evaluate expressions such as `x*y + z`, `(x*y + z) | w`, `(p | q) * r` or `(a + b)*(a + b)` over a stream of elements, with a new element accepted every cycle.

Each element presents all six external operand fields together with its valid strobe. The block holds these fields internally for as many cycles as the configured dataflow needs, so a stage that runs late in the chain sees the fields of its own element. The depth of a stage is 1 when both of its operands are external. Otherwise it is one more than the deepest stage it reads. The latency of the block equals the depth of the stage named by the final selector. A stage that the final selector does not reach, such as an unused OR unit, costs no latency.

The configuration is meant to be written between streams. A write that arrives while any element is in flight is refused. A write that names no stage as the result is also refused. Either refusal leaves the previous configuration in force and raises a sticky error flag.

Top module: `recon_arith_pipe`

## Requirements
- R1: The 14-bit configuration word holds 2-bit source codes. Bits [1:0] and [3:2] are multiplier operands a and b. Bits [5:4] and [7:6] are adder operands a and b. Bits [9:8] and [11:10] are OR operands a and b. Bits [13:12] are the final selector. For an operand, code 0 means the operand's own external field, 1 the multiplier register, 2 the adder register and 3 the OR register.
- R2: The multiplier keeps the low 16 bits of the unsigned product. The adder wraps modulo 2^16. The OR stage is a bitwise OR.
- R3: out_valid repeats in_valid delayed by L cycles. L is the depth of the stage chosen by the final selector: 1, 2 or 3.
- R4: Each stage uses the external operand fields that were presented with the same element as its chain inputs. Operand inputs that change after the element's valid cycle do not affect its result.
- R5: Final selector codes 1, 2 and 3 return the multiplier, adder and OR register on out_data. A path that leaves out a stage (for example multiply then OR, with the adder unused) gets no added latency from that stage.
- R6: A configuration write (cfg_load high) is accepted only when in_valid is low and no element is in flight in any of the three delay slots. It applies to elements presented after the write.
- R7: A write that is refused, either because the pipeline is busy or because the final selector is 0, leaves the configuration unchanged and sets cfg_err. cfg_err stays set until reset.
- R8: A synchronous reset clears all stage registers, the valid slots and cfg_err. It also restores the default configuration, which is multiplier(ext, ext) feeding adder operand a, adder operand b external, final selector = adder (word 0x2010).
- R9: Back-to-back elements, one per cycle, each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Configuration write strobe |
| cfg_word | input | 14 | Configuration word (fields in R1) |
| cfg_err | output | 1 | Sticky refused-write flag |
| in_valid | input | 1 | Stream element valid |
| op_mul_a | input | 16 | External operand a of the multiplier |
| op_mul_b | input | 16 | External operand b of the multiplier |
| op_add_a | input | 16 | External operand a of the adder |
| op_add_b | input | 16 | External operand b of the adder |
| op_or_a | input | 16 | External operand a of the OR stage |
| op_or_b | input | 16 | External operand b of the OR stage |
| out_valid | output | 1 | Result valid |
| out_data | output | 16 | Result from the stage named by the final selector |

## Verification
The bench builds the block with its default 16-bit operand width. At that width a product such as 0x1234*0x0100 loses its upper bits and an adder carry out of bit 15 is dropped, so both wrap rules can be checked with short hand-derived vectors. Chains of depth one, two and three are all reached, including a chain that skips the adder and one that reads the adder twice. This covers every latency and every source code on some operand.

// File: rtl/recon_pipe_pkg.sv
package recon_pipe_pkg;

    localparam int NSTG  = 3;
    localparam int NOPS  = 2 * NSTG;
    localparam int SEL_W = 2;
    localparam int CFG_W = SEL_W * NOPS + SEL_W;
    localparam int LVL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_EXT = 2'd0,
        SRC_MUL = 2'd1,
        SRC_ADD = 2'd2,
        SRC_OR  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        OP_MUL = 2'd0,
        OP_ADD = 2'd1,
        OP_OR  = 2'd2
    } stage_op_e;

    typedef struct packed {
        src_e b;
        src_e a;
    } opsel_t;

    typedef struct packed {
        src_e                  fin;
        opsel_t [NSTG-1:0]     st;
    } cfg_t;

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef lvl_t [NSTG-1:0]   lvl_vec_t;

    localparam logic [CFG_W-1:0] CFG_DEFAULT = 14'b10_00_00_00_01_00_00;

    function automatic int src_depth(input src_e s, input lvl_vec_t cur);
        int d;
        if (s == SRC_EXT) begin
            d = 0;
        end else begin
            d = int'(cur[int'(s) - 1]) + 1;
        end
        return d;
    endfunction

    function automatic lvl_vec_t calc_levels(input cfg_t c);
        lvl_vec_t cur;
        lvl_vec_t nxt;
        int       m;
        int       da;
        int       db;
        cur = '0;
        nxt = '0;
        for (int p = 0; p < NSTG; p++) begin
            for (int s = 0; s < NSTG; s++) begin
                da = src_depth(c.st[s].a, cur);
                db = src_depth(c.st[s].b, cur);
                m  = (da > db) ? da : db;
                if (m > NSTG - 1) begin
                    m = NSTG - 1;
                end
                nxt[s] = lvl_t'(m);
            end
            cur = nxt;
        end
        return cur;
    endfunction

endpackage

// File: rtl/rap_cfg_ctrl.sv
module rap_cfg_ctrl
    import recon_pipe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             busy,
    output cfg_t             cfg_q,
    output logic             cfg_err,
    output lvl_vec_t         lvl,
    output lvl_t             fin_lvl
);

    cfg_t cfg_in;
    logic accept;
    logic refuse;

    assign cfg_in = cfg_t'(cfg_word);
    assign accept = cfg_load && !busy && (cfg_in.fin != SRC_EXT);
    assign refuse = cfg_load && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= cfg_t'(CFG_DEFAULT);
            cfg_err <= 1'b0;
        end else begin
            if (accept) begin
                cfg_q <= cfg_in;
            end
            if (refuse) begin
                cfg_err <= 1'b1;
            end
        end
    end

    always_comb begin
        lvl = calc_levels(cfg_q);
        if (cfg_q.fin == SRC_EXT) begin
            fin_lvl = '0;
        end else begin
            fin_lvl = lvl[int'(cfg_q.fin) - 1];
        end
    end

endmodule

// File: rtl/rap_align.sv
module rap_align
    import recon_pipe_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [NOPS-1:0][DATA_W-1:0]   ext_in,
    input  lvl_vec_t                      lvl,
    output logic [NOPS-1:0][DATA_W-1:0]   ext_out,
    output logic [NSTG-1:0]               vpipe
);

    localparam int NDLY = NSTG - 1;

    logic [NDLY-1:0][NOPS-1:0][DATA_W-1:0] dreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            dreg  <= '0;
            vpipe <= '0;
        end else begin
            dreg[0] <= ext_in;
            for (int k = 1; k < NDLY; k++) begin
                dreg[k] <= dreg[k-1];
            end
            vpipe <= {vpipe[NSTG-2:0], in_valid};
        end
    end

    for (genvar i = 0; i < NOPS; i++) begin : g_tap
        localparam int ST = i / 2;
        always_comb begin
            if (lvl[ST] == '0) begin
                ext_out[i] = ext_in[i];
            end else begin
                ext_out[i] = dreg[int'(lvl[ST]) - 1][i];
            end
        end
    end

endmodule

// File: rtl/rap_stage.sv
module rap_stage
    import recon_pipe_pkg::*;
#(
    parameter int        DATA_W = 16,
    parameter stage_op_e OP     = OP_MUL
) (
    input  logic                          clk,
    input  logic                          rst,
    input  opsel_t                        sel,
    input  logic [DATA_W-1:0]             ext_a,
    input  logic [DATA_W-1:0]             ext_b,
    input  logic [NSTG-1:0][DATA_W-1:0]   fb,
    output logic [DATA_W-1:0]             q
);

    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] res;

    always_comb begin
        case (sel.a)
            SRC_EXT: opa = ext_a;
            SRC_MUL: opa = fb[0];
            SRC_ADD: opa = fb[1];
            default: opa = fb[2];
        endcase
        case (sel.b)
            SRC_EXT: opb = ext_b;
            SRC_MUL: opb = fb[0];
            SRC_ADD: opb = fb[1];
            default: opb = fb[2];
        endcase
    end

    if (OP == OP_MUL) begin : g_mul
        assign res = opa * opb;
    end else if (OP == OP_ADD) begin : g_add
        assign res = opa + opb;
    end else begin : g_or
        assign res = opa | opb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= res;
        end
    end

endmodule

// File: rtl/recon_arith_pipe.sv
module recon_arith_pipe
    import recon_pipe_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [CFG_W-1:0]  cfg_word,
    output logic              cfg_err,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_mul_a,
    input  logic [DATA_W-1:0] op_mul_b,
    input  logic [DATA_W-1:0] op_add_a,
    input  logic [DATA_W-1:0] op_add_b,
    input  logic [DATA_W-1:0] op_or_a,
    input  logic [DATA_W-1:0] op_or_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    cfg_t                         cfg_q;
    lvl_vec_t                     lvl;
    lvl_t                         fin_lvl;
    lvl_t                         lat;
    logic [NSTG-1:0]              vpipe;
    logic                         busy;
    logic [NOPS-1:0][DATA_W-1:0]  ext_in;
    logic [NOPS-1:0][DATA_W-1:0]  ext_al;
    logic [NSTG-1:0][DATA_W-1:0]  stq;

    assign ext_in = {op_or_b, op_or_a, op_add_b, op_add_a, op_mul_b, op_mul_a};
    assign busy   = in_valid || (|vpipe);
    assign lat    = fin_lvl + lvl_t'(1);

    rap_cfg_ctrl u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_load (cfg_load),
        .cfg_word (cfg_word),
        .busy     (busy),
        .cfg_q    (cfg_q),
        .cfg_err  (cfg_err),
        .lvl      (lvl),
        .fin_lvl  (fin_lvl)
    );

    rap_align #(.DATA_W(DATA_W)) u_align (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .ext_in   (ext_in),
        .lvl      (lvl),
        .ext_out  (ext_al),
        .vpipe    (vpipe)
    );

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        localparam stage_op_e OPK = stage_op_e'(s);
        rap_stage #(.DATA_W(DATA_W), .OP(OPK)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .sel   (cfg_q.st[s]),
            .ext_a (ext_al[2*s]),
            .ext_b (ext_al[2*s+1]),
            .fb    (stq),
            .q     (stq[s])
        );
    end

    always_comb begin
        out_valid = vpipe[fin_lvl];
        case (cfg_q.fin)
            SRC_ADD: out_data = stq[1];
            SRC_OR:  out_data = stq[2];
            default: out_data = stq[0];
        endcase
    end

endmodule

// File: rtl/recon_arith_pipe_chk.sv
module recon_arith_pipe_chk
    import recon_pipe_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  cfg_load,
    input logic  in_valid,
    input logic  out_valid,
    input logic  cfg_err,
    input cfg_t  cfg_q,
    input lvl_t  lat
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assert_valid_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == ((lat == 2'd1) ? $past(in_valid, 1) :
                                               (lat == 2'd2) ? $past(in_valid, 2) :
                                                               $past(in_valid, 3))));

    assert_cfg_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(cfg_q));

    assert_cfg_hold_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && in_valid) |=> ($stable(cfg_q) && cfg_err));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    assert_fin_named_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_q.fin != SRC_EXT);

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (!out_valid && !cfg_err));

endmodule

bind recon_arith_pipe recon_arith_pipe_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .cfg_err   (cfg_err),
    .cfg_q     (cfg_q),
    .lat       (lat)
);

// File: tb/test_recon_arith_pipe.sv
module test_recon_arith_pipe;

    localparam int NV = 8;
    localparam logic [1:0] E = 2'd0, M = 2'd1, A = 2'd2, O = 2'd3;

    function automatic logic [13:0] mk(input logic [1:0] ma, input logic [1:0] mb,
                                       input logic [1:0] aa, input logic [1:0] ab,
                                       input logic [1:0] oa, input logic [1:0] ob,
                                       input logic [1:0] fin);
        return {fin, ob, oa, ab, aa, mb, ma};
    endfunction

    // operand bundle order: {or_b, or_a, add_b, add_a, mul_b, mul_a}
    localparam logic [13:0] T_CFG [NV] = '{
        mk(E,E,M,E,E,E,A), mk(E,E,M,E,A,E,O), mk(E,E,E,E,E,E,M), mk(E,E,E,E,E,E,A),
        mk(O,E,E,E,E,E,M), mk(A,A,E,E,E,E,M), mk(A,E,O,E,E,E,M), mk(E,E,E,E,M,E,O)};
    localparam logic [95:0] T_OPS [NV] = '{
        {16'h0000, 16'h0000, 16'h0007, 16'hFFFF, 16'h0005, 16'h0003},
        {16'h8000, 16'h0000, 16'h0011, 16'h0000, 16'h0003, 16'h0100},
        {16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0100, 16'h1234},
        {16'h0000, 16'h0000, 16'h0020, 16'hFFF0, 16'h0000, 16'h0000},
        {16'h0004, 16'h0003, 16'h0000, 16'h0000, 16'h0009, 16'h0000},
        {16'h0000, 16'h0000, 16'h0003, 16'h0005, 16'h0000, 16'h0000},
        {16'h000F, 16'h00F0, 16'h0001, 16'h0000, 16'h0002, 16'h0000},
        {16'h0100, 16'h0000, 16'h0000, 16'h0000, 16'h0007, 16'h0006}};
    localparam logic [15:0] T_EXP [NV] = '{
        16'h0016, 16'h8311, 16'h3400, 16'h0010, 16'h003F, 16'h0040, 16'h0200, 16'h012A};
    localparam int T_LAT [NV] = '{2, 3, 1, 1, 2, 2, 3, 2};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [13:0] cfg_word = '0;
    logic        cfg_err;
    logic        in_valid = 1'b0;
    logic [15:0] op_mul_a = '0, op_mul_b = '0, op_add_a = '0, op_add_b = '0;
    logic [15:0] op_or_a = '0, op_or_b = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    recon_arith_pipe i_recon_arith_pipe (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_word(cfg_word), .cfg_err(cfg_err),
        .in_valid(in_valid), .op_mul_a(op_mul_a), .op_mul_b(op_mul_b),
        .op_add_a(op_add_a), .op_add_b(op_add_b), .op_or_a(op_or_a), .op_or_b(op_or_b),
        .out_valid(out_valid), .out_data(out_data));

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_ops(input logic [95:0] v);
        {op_or_b, op_or_a, op_add_b, op_add_a, op_mul_b, op_mul_a} = v;
    endtask

    task automatic load_cfg(input logic [13:0] w);
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_word = w;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // drive one element, scramble operands afterwards, check the result at cycle lat
    task automatic run_elem(input logic [95:0] ops, input logic [15:0] exp, input int lat,
                            input string req);
        @(negedge clk);
        in_valid = 1'b1;
        set_ops(ops);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            if (k == 1) begin
                in_valid = 1'b0;
                set_ops({6{16'hDEAD}});
            end
            if (k < lat) check(out_valid == 1'b0, {req, " early valid"}, 16'(out_valid), 16'h0);
            if (k == lat) begin
                check(out_valid == 1'b1, {req, " valid at latency"}, 16'(out_valid), 16'h1);
                check(out_data == exp, {req, " data"}, out_data, exp);
            end
        end
    endtask

    initial begin
        while (cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog actual %0d expected <5000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0, "R8 reset valid", 16'(out_valid), 16'h0);
        check(cfg_err == 1'b0, "R8 reset err", 16'(cfg_err), 16'h0);
        check(out_data == 16'h0, "R8 reset data", out_data, 16'h0);
        // R8: default configuration x*y+z without any load
        run_elem(T_OPS[0], 16'h0016, 2, "R8 default cfg");

        // R1 R2 R3 R4 R5 R6: table of configurations
        for (int i = 0; i < NV; i++) begin
            load_cfg(T_CFG[i]);
            run_elem(T_OPS[i], T_EXP[i], T_LAT[i], $sformatf("R1/R2/R3/R5 vec %0d", i));
        end
        check(cfg_err == 1'b0, "R6 idle loads accepted", 16'(cfg_err), 16'h0);

        // R9: back-to-back stream with x*y+z
        load_cfg(mk(E,E,M,E,E,E,A));
        for (int c = 0; c < 7; c++) begin
            @(negedge clk);
            if (c >= 2 && c - 2 < 4) begin
                check(out_valid == 1'b1, "R9 stream valid", 16'(out_valid), 16'h1);
                check(out_data == 16'((c) * (c + 1) + 10 * (c - 2)), "R9 stream data",
                      out_data, 16'((c) * (c + 1) + 10 * (c - 2)));
            end else begin
                check(out_valid == 1'b0, "R9 stream idle", 16'(out_valid), 16'h0);
            end
            if (c < 4) begin
                in_valid = 1'b1;
                set_ops({16'h0, 16'h0, 16'(10 * c), 16'hFFFF, 16'(c + 3), 16'(c + 2)});
            end else begin
                in_valid = 1'b0;
            end
        end

        // R7: final selector 0 refused, config unchanged
        repeat (3) @(negedge clk);
        load_cfg(mk(E,E,E,E,E,E,E));
        check(cfg_err == 1'b1, "R7 fin0 err", 16'(cfg_err), 16'h1);
        run_elem({16'h0, 16'h0, 16'h0001, 16'h0, 16'h0004, 16'h0004}, 16'h0011, 2,
                 "R7 fin0 cfg kept");

        // R8: reset with element in flight
        @(negedge clk);
        in_valid = 1'b1;
        set_ops({16'h0, 16'h0, 16'h0001, 16'h0, 16'h0004, 16'h0004});
        @(negedge clk);
        in_valid = 1'b0;
        set_ops('0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R8 flush valid", 16'(out_valid), 16'h0);
        check(cfg_err == 1'b0, "R8 err cleared", 16'(cfg_err), 16'h0);
        @(negedge clk);
        check(out_valid == 1'b0, "R8 no late valid", 16'(out_valid), 16'h0);

        // R6/R7: load while an element is in flight (in_valid already low)
        @(negedge clk);
        in_valid = 1'b1;
        set_ops({16'h0, 16'h0, 16'h0001, 16'h0, 16'h0004, 16'h0004});
        @(negedge clk);
        in_valid = 1'b0;
        set_ops({6{16'hDEAD}});
        cfg_load = 1'b1;
        cfg_word = mk(E,E,E,E,E,E,M);
        @(negedge clk);
        cfg_load = 1'b0;
        check(cfg_err == 1'b1, "R7 busy err", 16'(cfg_err), 16'h1);
        check(out_valid == 1'b1, "R6 in-flight valid", 16'(out_valid), 16'h1);
        check(out_data == 16'h0011, "R6 in-flight data", out_data, 16'h0011);
        repeat (3) @(negedge clk);
        run_elem({16'h0, 16'h0, 16'h0001, 16'h0, 16'h0004, 16'h0004}, 16'h0011, 2,
                 "R7 busy cfg kept");
        check(cfg_err == 1'b1, "R7 err sticky", 16'(cfg_err), 16'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule